// File: doc/BRIEF.md
# Switching Clock Sync and Spread-Spectrum Selector

This block watches a single pin that a board may tie low, tie high, or drive with an external square wave. After synchronising the pin into the system clock domain it measures the spacing of rising edges in system clock cycles. From that spacing and the pin's resting level it picks the clock source for a switching regulator's oscillator:
- the internal clock with no modulation;
- the internal clock with spread spectrum;
- the external clock, to which the oscillator is locked.

In spread mode the block produces a signed trim word that follows a triangle wave. The trim word is added to the divider of an internal oscillator, and its extremes stand for a deviation of about plus and minus three percent from the centre frequency. With the default parameters the triangle repeats once per millisecond.

An external clock is accepted only when its period lies inside a programmed window of system clock cycles. With the defaults at 100 MHz, that window covers roughly 300 kHz to 2.2 MHz. If edges stop arriving, the lock is dropped. The fallback then depends on the level at which the pin rests:
- **Rests low:** the non-modulated internal clock is used at once.
- **Rests high:** modulation returns only after the pin has stayed high for a hold time of 256 µs by default.

The 1.2 to 1.5 ratio between the external frequency and the internal set frequency is a constraint on the board, not on this logic.

Top module: `sync_clk_sel`

## Requirements
- R1: After reset, and whenever the synchronised pin is low while no external clock is locked, `mode_o` is 0 (internal, no modulation), `use_ext_o` is 0 and `trim_o` is 0.
- R2: With the pin high and no lock, `mode_o` remains 0 until the synchronised pin has been high for HIGH_HOLD consecutive system cycles. From then on `mode_o` is 1 (internal with spread spectrum).
- R3: A rising edge whose distance from the previous rising edge is between MIN_PER and MAX_PER system cycles, both ends included, sets the lock. While the lock is set, `mode_o` is 2 and `use_ext_o` is 1 (both visible one cycle after the synchronised edge), and `trim_o` is 0.
- R4: A rising edge whose distance from the previous rising edge is below MIN_PER or above MAX_PER clears the lock, so a pin toggling too fast or too slow never selects mode 2.
- R5: When no rising edge arrives for MAX_PER+1 cycles after the last one, the lock clears. If the pin then rests low, `mode_o` is 0 in the same cycle.
- R6: When the lock clears with the pin resting high, `mode_o` is 0 until the pin has been high for HIGH_HOLD cycles counted from the loss of lock, and 1 after that.
- R7: In mode 1, `trim_o` starts at 0 and moves by exactly one every STEP_CYC cycles. It rises to +TRIM_MAX, falls to -TRIM_MAX and rises again, for a full period of 4·TRIM_MAX·STEP_CYC cycles. It never leaves ±TRIM_MAX.
- R8: Outside mode 1, `trim_o` is 0. Each new entry into mode 1 restarts the triangle from 0 going up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Raw pin: static level or external clock |
| mode_o | output | 2 | 0 internal fixed, 1 internal spread, 2 external |
| use_ext_o | output | 1 | High while locked to the external clock |
| trim_o | output | TRIM_W | Signed frequency trim for the oscillator divider |

## Verification
The pin passes through two synchroniser flops, so a level change on `sync_i` reaches `mode_o` in the third cycle after it is driven. The timing of the other results follows from that:
- A lock decision appears one cycle after the synchronised edge.
- A loss of lock appears MAX_PER+2 cycles after the last synchronised edge.
- The spread decision appears HIGH_HOLD+1 cycles after the synchronised level rises.

A behavioural reference model in the bench advances its own counters on each rising clock edge. Its outputs are compared with all three outputs at every falling edge, so each of these latencies is checked in the exact cycle it is due. Point checks at chosen waits confirm the mode reached in each scenario, including both period boundaries and both fallback levels.

// File: rtl/sync_clk_pkg.sv
package sync_clk_pkg;
  typedef enum logic [1:0] {
    CM_FIXED  = 2'd0,
    CM_SPREAD = 2'd1,
    CM_EXT    = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/sync_in_stage.sv
module sync_in_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~s3_q;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int MIN_PER = 45,
  parameter int MAX_PER = 334
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic lock_o
);
  localparam int LIMIT = MAX_PER + 1;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_PER);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_PER);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          lock_q;
  logic          in_win;

  // cnt_q == 0 means no edge seen since reset
  assign in_win = (cnt_q >= MIN_C) && (cnt_q <= MAX_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q  <= CW'(1);
      lock_q <= in_win;
    end else begin
      if (cnt_q != '0 && cnt_q != LIM_C) cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LIM_C) lock_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/mode_sel.sv
module mode_sel
  import sync_clk_pkg::*;
#(
  parameter int HIGH_HOLD = 25600
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      level_i,
  input  logic      lock_i,
  output clk_mode_e mode_o
);
  localparam int HW = $clog2(HIGH_HOLD + 1);
  localparam logic [HW-1:0] HOLD_C = HW'(HIGH_HOLD);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= '0;
    else if (lock_i || !level_i) hold_q <= '0;
    else if (hold_q != HOLD_C)   hold_q <= hold_q + HW'(1);
  end

  // low level falls back at once; high level waits out the hold
  always_comb begin
    if (lock_i)                           mode_o = CM_EXT;
    else if (level_i && hold_q == HOLD_C) mode_o = CM_SPREAD;
    else                                  mode_o = CM_FIXED;
  end
endmodule

// File: rtl/ss_triangle.sv
module ss_triangle #(
  parameter int TRIM_MAX = 30,
  parameter int STEP_CYC = 833,
  parameter int TRIM_W   = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  output logic signed [TRIM_W-1:0] trim_o
);
  localparam int DW = $clog2(STEP_CYC + 1);
  localparam logic [DW-1:0] LAST_C = DW'(STEP_CYC - 1);
  localparam logic signed [TRIM_W-1:0] TOP = TRIM_W'(TRIM_MAX);
  localparam logic signed [TRIM_W-1:0] BOT = -TOP;
  localparam logic signed [TRIM_W-1:0] ONE = TRIM_W'(1);

  logic [DW-1:0]            div_q;
  logic signed [TRIM_W-1:0] val_q;
  logic                     up_q;
  logic signed [TRIM_W-1:0] val_nx;

  assign val_nx = up_q ? (val_q + ONE) : (val_q - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      val_q <= '0;
      up_q  <= 1'b1;
    end else if (!run_i) begin
      div_q <= '0;
      val_q <= '0;
      up_q  <= 1'b1;
    end else if (div_q == LAST_C) begin
      div_q <= '0;
      val_q <= val_nx;
      if (val_nx == TOP) up_q <= 1'b0;
      if (val_nx == BOT) up_q <= 1'b1;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  assign trim_o = run_i ? val_q : '0;
endmodule

// File: rtl/sync_clk_sel.sv
module sync_clk_sel
  import sync_clk_pkg::*;
#(
  parameter int MIN_PER   = 45,
  parameter int MAX_PER   = 334,
  parameter int HIGH_HOLD = 25600,
  parameter int TRIM_MAX  = 30,
  parameter int STEP_CYC  = 833,
  localparam int TRIM_W   = $clog2(TRIM_MAX + 1) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_i,
  output logic [1:0]               mode_o,
  output logic                     use_ext_o,
  output logic signed [TRIM_W-1:0] trim_o
);
  logic      level, rise, lock;
  clk_mode_e mode;

  sync_in_stage u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sync_i),
    .level_o(level),
    .rise_o (rise)
  );

  period_meter #(.MIN_PER(MIN_PER), .MAX_PER(MAX_PER)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .lock_o(lock)
  );

  mode_sel #(.HIGH_HOLD(HIGH_HOLD)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level),
    .lock_i (lock),
    .mode_o (mode)
  );

  ss_triangle #(.TRIM_MAX(TRIM_MAX), .STEP_CYC(STEP_CYC), .TRIM_W(TRIM_W)) u_tri (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (mode == CM_SPREAD),
    .trim_o(trim_o)
  );

  assign mode_o    = mode;
  assign use_ext_o = lock;
endmodule

// File: rtl/sync_clk_sel_chk.sv
module sync_clk_sel_chk #(
  parameter int TRIM_MAX = 30,
  localparam int TW      = $clog2(TRIM_MAX + 1) + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sync_i,
  input logic [1:0]           mode_o,
  input logic                 use_ext_o,
  input logic signed [TW-1:0] trim_o
);
  localparam logic signed [TW-1:0] TOP = TW'(TRIM_MAX);

  p_trim_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd1 |-> trim_o == '0);

  p_trim_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_o <= TOP) && (trim_o >= -TOP));

  p_trim_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && $past(mode_o) == 2'd1) |->
      ((trim_o - $past(trim_o)) == '0 || (trim_o - $past(trim_o)) == TW'(1)
       || ($past(trim_o) - trim_o) == TW'(1)));

  p_ext_no_trim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_ext_o |-> (mode_o == 2'd2 && trim_o == '0));

  p_spread_pin_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd1 |-> $past(sync_i, 2));
endmodule

bind sync_clk_sel sync_clk_sel_chk #(.TRIM_MAX(TRIM_MAX)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sync_i   (sync_i),
  .mode_o   (mode_o),
  .use_ext_o(use_ext_o),
  .trim_o   (trim_o)
);

// File: tb/sync_clk_sel_bench.sv
`timescale 1ns/1ps
module sync_clk_sel_bench;
  localparam int MINP = 4;
  localparam int MAXP = 20;
  localparam int HOLD = 100;
  localparam int TM   = 6;
  localparam int STEP = 3;
  localparam int TW   = $clog2(TM + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic [1:0] mode;
  logic use_ext;
  logic signed [TW-1:0] trim;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";
  int tmax = -100, tmin = 100;

  always #5 clk = ~clk;

  sync_clk_sel #(.MIN_PER(MINP), .MAX_PER(MAXP), .HIGH_HOLD(HOLD),
                 .TRIM_MAX(TM), .STEP_CYC(STEP)) u_sync_clk_sel (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(pin),
    .mode_o(mode), .use_ext_o(use_ext), .trim_o(trim));

  // reference model state
  int ms1, ms2, ms3, mcnt, mlock, mhold, mdiv, mval, mup;

  function automatic int exp_mode();
    if (mlock != 0) return 2;
    if (ms2 != 0 && mhold == HOLD) return 1;
    return 0;
  endfunction

  function automatic int exp_trim();
    return (exp_mode() == 1) ? mval : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; ms3 = 0; mcnt = 0; mlock = 0;
      mhold = 0; mdiv = 0; mval = 0; mup = 1;
    end else begin
      int rise, run, ncnt, nlock, nhold, ndiv, nval, nup, v;
      rise = (ms2 != 0 && ms3 == 0);
      run  = (exp_mode() == 1);
      if (rise) begin
        ncnt = 1;
        nlock = (mcnt >= MINP && mcnt <= MAXP);
      end else begin
        ncnt = (mcnt != 0 && mcnt != MAXP + 1) ? mcnt + 1 : mcnt;
        nlock = (mcnt == MAXP + 1) ? 0 : mlock;
      end
      if (mlock != 0 || ms2 == 0) nhold = 0;
      else nhold = (mhold < HOLD) ? mhold + 1 : HOLD;
      ndiv = mdiv; nval = mval; nup = mup;
      if (!run) begin
        ndiv = 0; nval = 0; nup = 1;
      end else if (mdiv == STEP - 1) begin
        ndiv = 0;
        v = (mup != 0) ? mval + 1 : mval - 1;
        nval = v;
        if (v == TM) nup = 0;
        if (v == -TM) nup = 1;
      end else begin
        ndiv = mdiv + 1;
      end
      ms3 = ms2; ms2 = ms1; ms1 = int'(pin);
      mcnt = ncnt; mlock = nlock; mhold = nhold;
      mdiv = ndiv; mval = nval; mup = nup;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (int'(mode) != exp_mode() || int'(use_ext) != mlock ||
          int'(trim) != exp_trim()) begin
        mismatched++;
        $display("FAIL %s model: mode %0d/%0d use_ext %0d/%0d trim %0d/%0d (act/exp)",
                 tag, mode, exp_mode(), use_ext, mlock, trim, exp_trim());
      end
      if (mode == 2'd1) begin
        if (int'(trim) > tmax) tmax = int'(trim);
        if (int'(trim) < tmin) tmin = int'(trim);
      end
    end
  end

  task automatic check(string req, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic hold_level(bit lvl, int n);
    @(negedge clk);
    pin = lvl;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic toggle(int per, int n);
    for (int i = 0; i < n; i++) begin
      hold_level(1'b1, per / 2);
      hold_level(1'b0, per - per / 2);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset mode", int'(mode), 0);
    check("R1 reset trim", int'(trim), 0);
    rst_n = 1'b1;
    tag = "R1";
    hold_level(1'b0, 50);
    check("R1 low mode", int'(mode), 0);
    check("R1 low use_ext", int'(use_ext), 0);

    tag = "R2";
    hold_level(1'b1, 60);
    check("R2 before hold", int'(mode), 0);
    hold_level(1'b1, 60);
    check("R2 after hold", int'(mode), 1);
    tag = "R7";
    tmax = -100; tmin = 100;
    hold_level(1'b1, 4 * TM * STEP + 10);
    check("R7 top extreme", tmax, TM);
    check("R7 bottom extreme", tmin, -TM);

    tag = "R8";
    hold_level(1'b0, 5);
    check("R8 trim after exit", int'(trim), 0);
    hold_level(1'b1, HOLD + 4);
    check("R8 restart at zero", int'(trim), 0);
    hold_level(1'b1, STEP);
    check("R8 first step up", int'(trim), 1);

    tag = "R3";
    hold_level(1'b0, 5);
    toggle(10, 20);
    check("R3 lock mode", int'(mode), 2);
    check("R3 use_ext", int'(use_ext), 1);
    check("R3 trim zero", int'(trim), 0);
    toggle(MINP, 10);
    check("R3 min period", int'(mode), 2);
    toggle(MAXP, 5);
    check("R3 max period", int'(mode), 2);

    tag = "R5";
    hold_level(1'b0, MAXP + 6);
    check("R5 lost low", int'(mode), 0);
    check("R5 use_ext cleared", int'(use_ext), 0);

    tag = "R6";
    toggle(10, 10);
    check("R6 relock", int'(mode), 2);
    hold_level(1'b1, MAXP + 10);
    check("R6 lost high no spread", int'(mode), 0);
    hold_level(1'b1, HOLD);
    check("R6 spread after hold", int'(mode), 1);

    tag = "R4";
    hold_level(1'b0, 5);
    toggle(MINP - 1, 20);
    check("R4 too fast", int'(use_ext), 0);
    toggle(MAXP + 2, 8);
    check("R4 too slow", int'(use_ext), 0);
    check("R4 too slow mode", int'(mode) == 2 ? 1 : 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule